// File: doc/BRIEF.md
# Snooping Coherent Bus Router

This block joins several cache-side ports to one memory-side port. Each cycle it moves at most one cache request toward memory, one response from memory back to a cache, one snoop broadcast and one snoop response. A request that targets a cacheable region is copied as a snoop to every cache port except the one that issued it. A cache that can answer the snoop raises a claim in the same cycle, and the bus then marks the memory request as inhibited so that memory stays silent. Responses from memory carry the port ID that the request left with, and that ID steers them back.

All transfers are combinational from inputs to outputs in the cycle they are accepted. The only state is a busy counter and a round-robin pointer. When a cycle delivers anything to a cache-side port, or returns a snoop response to memory, the bus reloads the counter from `busy_len`. While the counter is non-zero the bus refuses new cache requests, memory responses and memory snoops. Snoop responses are still accepted and routed while the bus is busy.

Top module: `snoop_xbar`

## Requirements
- R1: A granted cache request appears on the memory side in the same cycle with its kind and address, and with `m_req_src` equal to the requesting port index.
- R2: A granted request with `c_req_cacheable`=1 raises `snp_valid` on every other cache port, and not on the requester. `snp_origin` is set to the requester index. An uncacheable request raises no snoop.
- R3: An accepted memory response raises `c_resp_valid` only on the port numbered by `m_resp_dst`. Kind code 2 (upgrade) gives `c_resp_has_data`=0 and zero data. Every other kind gives `c_resp_has_data`=1 and passes the data through.
- R4: An accepted memory snoop is broadcast to all cache ports with `snp_origin`=N. It wins over cache requests, so no cache request is granted in that cycle.
- R5: A snoop response whose origin field is N goes out on `m_sresp_valid`/`m_sresp_data`. An origin j below N is forwarded on `fwd_sresp_valid[j]` with its data.
- R6: After a cycle in which any of `snp_valid`, `c_resp_valid`, `fwd_sresp_valid` or `m_sresp_valid` is high, `busy` is high for exactly the next `busy_len` cycles. It is never high when no such cycle has occurred within the last `busy_len` cycles.
- R7: While `busy` is high, `c_req_ready`, `m_resp_ready` and `m_snp_ready` are all low, and snoop responses are still routed as in R5.
- R8: `m_req_inhibit` is high when a cacheable request is granted and at least one port that received its snoop raises `snp_claim`. Otherwise it is low.
- R9: `snp_inval` is high with a snoop of kind code 1 (read-exclusive) or 2 (upgrade), and low for code 0 (read) and code 3 (write).
- R10: Among cache ports requesting together, the grant goes to the first one found at or after the round-robin pointer, counting upward with wrap. After each grant the pointer moves to the port just after the winner.
- R11: After reset `busy` is low and the round-robin pointer is at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| busy_len | input | CW | busy cycles after a send |
| c_req_valid | input | N | request present per cache port |
| c_req_kind | input | 2*N | request kind per port (0 read, 1 read-exclusive, 2 upgrade, 3 write) |
| c_req_addr | input | AW*N | request address per port |
| c_req_cacheable | input | N | request targets a cacheable region |
| c_req_ready | output | N | request accepted this cycle |
| snp_valid | output | N | snoop delivered to cache port |
| snp_kind | output | 2 | snoop kind |
| snp_addr | output | AW | snoop address |
| snp_origin | output | IDW | snoop originator (N = memory side) |
| snp_inval | output | 1 | snoop invalidates other copies |
| snp_claim | input | N | cache will answer this snoop |
| c_sresp_valid | input | N | snoop response from cache port |
| c_sresp_origin | input | IDW*N | originator the response returns to |
| c_sresp_data | input | DW*N | snoop response data |
| fwd_sresp_valid | output | N | snoop response delivered to cache port |
| fwd_sresp_data | output | DW | forwarded snoop response data |
| c_resp_valid | output | N | memory response delivered to cache port |
| c_resp_kind | output | 2 | response kind |
| c_resp_has_data | output | 1 | response carries a line |
| c_resp_data | output | DW | response data |
| m_req_valid | output | 1 | request to memory |
| m_req_kind | output | 2 | request kind |
| m_req_addr | output | AW | request address |
| m_req_src | output | IDW | requesting port index |
| m_req_inhibit | output | 1 | a cache answers, memory must not |
| m_resp_valid | input | 1 | response from memory |
| m_resp_dst | input | IDW | destination port of response |
| m_resp_kind | input | 2 | response kind |
| m_resp_data | input | DW | response data |
| m_resp_ready | output | 1 | memory response accepted |
| m_snp_valid | input | 1 | snoop from memory side |
| m_snp_kind | input | 2 | memory snoop kind |
| m_snp_addr | input | AW | memory snoop address |
| m_snp_ready | output | 1 | memory snoop accepted |
| m_sresp_valid | output | 1 | snoop response to memory side |
| m_sresp_data | output | DW | snoop response data to memory side |
| busy | output | 1 | bus is in its busy period |

## Verification
The assertions assume three things about the inputs. At most one cache port returns a snoop response in any cycle. A port never names itself as the originator of its own snoop response. `m_resp_dst` always names an existing cache port. The random stimulus draws at most one responder per cycle, and it picks that responder's origin from the other ports or the memory ID. It draws the response destination from 0 to N-1. The stimulus also changes `busy_len` between phases, including zero, so that both back-to-back traffic and blocked periods are exercised.

// File: rtl/snoop_xbar_pkg.sv
package snoop_xbar_pkg;
    typedef enum logic [1:0] {
        KIND_READ    = 2'd0,
        KIND_READEX  = 2'd1,
        KIND_UPGRADE = 2'd2,
        KIND_WRITE   = 2'd3
    } xkind_e;

    function automatic logic kind_invalidates(input logic [1:0] k);
        return (k == KIND_READEX) || (k == KIND_UPGRADE);
    endfunction

    function automatic logic kind_has_data(input logic [1:0] k);
        return k != KIND_UPGRADE;
    endfunction
endpackage

// File: rtl/snoop_xbar_rr.sv
module snoop_xbar_rr #(
    parameter int N  = 3,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [PW-1:0] gnt_idx,
    output logic          any
);
    int p;
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        p       = 0;
        for (int k = 0; k < N; k++) begin
            p = (int'(ptr) + k) % N;
            if (!any && req[p]) begin
                any     = 1'b1;
                gnt[p]  = 1'b1;
                gnt_idx = PW'(p);
            end
        end
    end
endmodule

// File: rtl/snoop_xbar_sresp.sv
module snoop_xbar_sresp #(
    parameter int N   = 3,
    parameter int IDW = 2,
    parameter int DW  = 8
) (
    input  logic [N-1:0]     in_valid,
    input  logic [IDW*N-1:0] in_origin,
    input  logic [DW*N-1:0]  in_data,
    output logic             to_mem_valid,
    output logic [DW-1:0]    to_mem_data,
    output logic [N-1:0]     to_port_valid,
    output logic [DW-1:0]    to_port_data
);
    localparam logic [IDW-1:0] MEM_ID = IDW'(N);

    logic           found;
    logic [IDW-1:0] org;
    logic [DW-1:0]  dat;

    always_comb begin
        found = 1'b0;
        org   = '0;
        dat   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && in_valid[i]) begin
                found = 1'b1;
                org   = in_origin[i*IDW +: IDW];
                dat   = in_data[i*DW +: DW];
            end
        end
    end

    assign to_mem_valid = found && (org == MEM_ID);
    assign to_mem_data  = to_mem_valid ? dat : '0;

    for (genvar j = 0; j < N; j++) begin : g_port
        assign to_port_valid[j] = found && (org == IDW'(j));
    end
    assign to_port_data = (|to_port_valid) ? dat : '0;
endmodule

// File: rtl/snoop_xbar.sv
module snoop_xbar
    import snoop_xbar_pkg::*;
#(
    parameter int N   = 3,
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int CW  = 4,
    parameter int IDW = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    busy_len,
    input  logic [N-1:0]     c_req_valid,
    input  logic [2*N-1:0]   c_req_kind,
    input  logic [AW*N-1:0]  c_req_addr,
    input  logic [N-1:0]     c_req_cacheable,
    output logic [N-1:0]     c_req_ready,
    output logic [N-1:0]     snp_valid,
    output logic [1:0]       snp_kind,
    output logic [AW-1:0]    snp_addr,
    output logic [IDW-1:0]   snp_origin,
    output logic             snp_inval,
    input  logic [N-1:0]     snp_claim,
    input  logic [N-1:0]     c_sresp_valid,
    input  logic [IDW*N-1:0] c_sresp_origin,
    input  logic [DW*N-1:0]  c_sresp_data,
    output logic [N-1:0]     fwd_sresp_valid,
    output logic [DW-1:0]    fwd_sresp_data,
    output logic [N-1:0]     c_resp_valid,
    output logic [1:0]       c_resp_kind,
    output logic             c_resp_has_data,
    output logic [DW-1:0]    c_resp_data,
    output logic             m_req_valid,
    output logic [1:0]       m_req_kind,
    output logic [AW-1:0]    m_req_addr,
    output logic [IDW-1:0]   m_req_src,
    output logic             m_req_inhibit,
    input  logic             m_resp_valid,
    input  logic [IDW-1:0]   m_resp_dst,
    input  logic [1:0]       m_resp_kind,
    input  logic [DW-1:0]    m_resp_data,
    output logic             m_resp_ready,
    input  logic             m_snp_valid,
    input  logic [1:0]       m_snp_kind,
    input  logic [AW-1:0]    m_snp_addr,
    output logic             m_snp_ready,
    output logic             m_sresp_valid,
    output logic [DW-1:0]    m_sresp_data,
    output logic             busy
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDW-1:0] MEM_ID = IDW'(N);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] ptr;
    } state_t;

    state_t s_q, s_d;

    logic [N-1:0]  arb_req_d;
    logic [N-1:0]  arb_gnt;
    logic [PW-1:0] arb_idx;
    logic          arb_any;

    snoop_xbar_rr #(.N(N), .PW(PW)) u_rr (
        .req     (arb_req_d),
        .ptr     (s_q.ptr),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .any     (arb_any)
    );

    snoop_xbar_sresp #(.N(N), .IDW(IDW), .DW(DW)) u_sresp (
        .in_valid      (c_sresp_valid),
        .in_origin     (c_sresp_origin),
        .in_data       (c_sresp_data),
        .to_mem_valid  (m_sresp_valid),
        .to_mem_data   (m_sresp_data),
        .to_port_valid (fwd_sresp_valid),
        .to_port_data  (fwd_sresp_data)
    );

    logic [N-1:0] resp_hit_d;
    for (genvar j = 0; j < N; j++) begin : g_dst
        assign resp_hit_d[j] = (m_resp_dst == IDW'(j));
    end

    logic msnp_take_d, resp_take_d, req_cach_d, send_ev_d;

    always_comb begin
        s_d          = s_q;
        busy         = (s_q.cnt != '0);
        m_snp_ready  = !busy;
        m_resp_ready = !busy;
        msnp_take_d  = m_snp_valid && !busy;
        arb_req_d    = (busy || msnp_take_d) ? '0 : c_req_valid;
        c_req_ready  = arb_gnt;

        req_cach_d    = arb_any && c_req_cacheable[arb_idx];
        m_req_valid   = arb_any;
        m_req_kind    = arb_any ? c_req_kind[arb_idx*2 +: 2] : '0;
        m_req_addr    = arb_any ? c_req_addr[arb_idx*AW +: AW] : '0;
        m_req_src     = arb_any ? IDW'(arb_idx) : '0;

        snp_valid  = '0;
        snp_kind   = '0;
        snp_addr   = '0;
        snp_origin = '0;
        if (msnp_take_d) begin
            snp_valid  = '1;
            snp_kind   = m_snp_kind;
            snp_addr   = m_snp_addr;
            snp_origin = MEM_ID;
        end else if (req_cach_d) begin
            snp_valid  = ~arb_gnt;
            snp_kind   = m_req_kind;
            snp_addr   = m_req_addr;
            snp_origin = m_req_src;
        end
        snp_inval     = (|snp_valid) && kind_invalidates(snp_kind);
        m_req_inhibit = req_cach_d && |(snp_claim & snp_valid);

        resp_take_d     = m_resp_valid && !busy;
        c_resp_valid    = resp_take_d ? resp_hit_d : '0;
        c_resp_kind     = resp_take_d ? m_resp_kind : '0;
        c_resp_has_data = resp_take_d && kind_has_data(m_resp_kind);
        c_resp_data     = c_resp_has_data ? m_resp_data : '0;

        send_ev_d = (|snp_valid) || (|c_resp_valid) || (|fwd_sresp_valid) || m_sresp_valid;
        if (send_ev_d)
            s_d.cnt = busy_len;
        else if (busy)
            s_d.cnt = s_q.cnt - 1'b1;

        if (arb_any)
            s_d.ptr = (arb_idx == PW'(N - 1)) ? '0 : arb_idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end
endmodule

// File: rtl/snoop_xbar_chk.sv
module snoop_xbar_chk #(
    parameter int N   = 3,
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int CW  = 4,
    parameter int IDW = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CW-1:0]    busy_len,
    input logic [N-1:0]     c_req_valid,
    input logic [N-1:0]     c_req_ready,
    input logic [N-1:0]     snp_valid,
    input logic [1:0]       snp_kind,
    input logic             snp_inval,
    input logic [N-1:0]     fwd_sresp_valid,
    input logic [N-1:0]     c_resp_valid,
    input logic             m_req_valid,
    input logic             m_resp_valid,
    input logic             m_resp_ready,
    input logic             m_snp_valid,
    input logic             m_snp_ready,
    input logic             m_sresp_valid,
    input logic             busy
);
    p_ready_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req_ready & ~c_req_valid) == '0);

    p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_req_ready) && (m_req_valid == (|c_req_ready)));

    p_no_self_snoop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid & c_req_ready) == '0);

    p_resp_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_resp_valid && m_resp_ready) |-> $countones(c_resp_valid) == 1);

    p_msnp_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_snp_valid && m_snp_ready) |-> (c_req_ready == '0) && (snp_valid == '1));

    p_busy_after_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((|snp_valid) || (|c_resp_valid) || (|fwd_sresp_valid) || m_sresp_valid)
         && busy_len != '0) |=> busy);

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (c_req_ready == '0) && !m_resp_ready && !m_snp_ready);

    p_inval_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|snp_valid && (snp_kind == 2'd0 || snp_kind == 2'd3)) |-> !snp_inval);
endmodule

bind snoop_xbar snoop_xbar_chk #(.N(N), .AW(AW), .DW(DW), .CW(CW), .IDW(IDW)) u_chk (.*);

// File: tb/snoop_xbar_test.sv
module snoop_xbar_test;
    localparam int N = 3, AW = 8, DW = 8, CW = 4, IDW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CW-1:0] busy_len = '0;
    logic [N-1:0] c_req_valid = '0, c_req_cacheable = '0, snp_claim = '0, c_sresp_valid = '0;
    logic [2*N-1:0] c_req_kind = '0;
    logic [AW*N-1:0] c_req_addr = '0;
    logic [IDW*N-1:0] c_sresp_origin = '0;
    logic [DW*N-1:0] c_sresp_data = '0;
    logic m_resp_valid = 1'b0, m_snp_valid = 1'b0;
    logic [IDW-1:0] m_resp_dst = '0;
    logic [1:0] m_resp_kind = '0, m_snp_kind = '0;
    logic [DW-1:0] m_resp_data = '0;
    logic [AW-1:0] m_snp_addr = '0;

    logic [N-1:0] c_req_ready, snp_valid, fwd_sresp_valid, c_resp_valid;
    logic [1:0] snp_kind, c_resp_kind, m_req_kind;
    logic [AW-1:0] snp_addr, m_req_addr;
    logic [IDW-1:0] snp_origin, m_req_src;
    logic snp_inval, c_resp_has_data, m_req_valid, m_req_inhibit;
    logic m_resp_ready, m_snp_ready, m_sresp_valid, busy;
    logic [DW-1:0] fwd_sresp_data, c_resp_data, m_sresp_data;

    snoop_xbar #(.N(N), .AW(AW), .DW(DW), .CW(CW), .IDW(IDW)) uut (.*);

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int m_cnt = 0, m_ptr = 0;
    bit ev;
    int grant;

    task automatic compare_cycle();
        bit bz, ms, cach;
        logic [N-1:0] e_rdy, e_snp, e_resp, e_fwd;
        logic [1:0] sk;
        logic [AW-1:0] sa;
        int so, sp, org;
        bz = (m_cnt != 0);
        ms = m_snp_valid && !bz;
        grant = -1;
        if (!bz && !ms)
            for (int k = 0; k < N; k++)
                if (grant < 0 && c_req_valid[(m_ptr + k) % N]) grant = (m_ptr + k) % N;
        e_rdy = '0;
        if (grant >= 0) e_rdy[grant] = 1'b1;
        check("R10", "c_req_ready", c_req_ready, e_rdy);
        check("R7", "busy", busy, bz);
        check("R7", "m_resp_ready", m_resp_ready, !bz);
        check("R7", "m_snp_ready", m_snp_ready, !bz);
        check("R1", "m_req_valid", m_req_valid, grant >= 0);
        cach = 1'b0;
        if (grant >= 0) begin
            check("R1", "m_req_kind", m_req_kind, c_req_kind[grant*2 +: 2]);
            check("R1", "m_req_addr", m_req_addr, c_req_addr[grant*AW +: AW]);
            check("R1", "m_req_src", m_req_src, grant);
            cach = c_req_cacheable[grant];
        end
        e_snp = '0; sk = '0; sa = '0; so = 0;
        if (ms) begin
            e_snp = '1; sk = m_snp_kind; sa = m_snp_addr; so = N;
        end else if (cach) begin
            for (int i = 0; i < N; i++) e_snp[i] = (i != grant);
            sk = c_req_kind[grant*2 +: 2]; sa = c_req_addr[grant*AW +: AW]; so = grant;
        end
        check(ms ? "R4" : "R2", "snp_valid", snp_valid, e_snp);
        if (e_snp != 0) begin
            check(ms ? "R4" : "R2", "snp_addr", snp_addr, sa);
            check(ms ? "R4" : "R2", "snp_origin", snp_origin, so);
            check("R9", "snp_inval", snp_inval, (sk == 2'd1 || sk == 2'd2));
        end
        check("R8", "m_req_inhibit", m_req_inhibit, cach && ((snp_claim & e_snp) != 0));
        e_resp = '0;
        if (m_resp_valid && !bz) e_resp[m_resp_dst] = 1'b1;
        check("R3", "c_resp_valid", c_resp_valid, e_resp);
        if (e_resp != 0) begin
            check("R3", "c_resp_has_data", c_resp_has_data, m_resp_kind != 2'd2);
            check("R3", "c_resp_data", c_resp_data, (m_resp_kind != 2'd2) ? m_resp_data : '0);
        end
        e_fwd = '0; sp = -1; org = 0;
        for (int i = 0; i < N; i++) if (c_sresp_valid[i]) begin sp = i; org = c_sresp_origin[i*IDW +: IDW]; end
        if (sp >= 0 && org < N) e_fwd[org] = 1'b1;
        check("R5", "m_sresp_valid", m_sresp_valid, sp >= 0 && org == N);
        check("R5", "fwd_sresp_valid", fwd_sresp_valid, e_fwd);
        if (sp >= 0 && org == N) check("R5", "m_sresp_data", m_sresp_data, c_sresp_data[sp*DW +: DW]);
        if (e_fwd != 0) check("R5", "fwd_sresp_data", fwd_sresp_data, c_sresp_data[sp*DW +: DW]);
        ev = (e_snp != 0) || (e_resp != 0) || (sp >= 0);
    endtask

    task automatic drive_random(input int load);
        c_req_valid = '0;
        for (int i = 0; i < N; i++) c_req_valid[i] = ($urandom_range(99) < load);
        c_req_kind = N*2'($urandom);
        c_req_addr = (AW*N)'({$urandom, $urandom});
        c_req_cacheable = N'($urandom);
        snp_claim = N'($urandom);
        m_resp_valid = ($urandom_range(99) < load / 2);
        m_resp_dst = IDW'($urandom_range(N - 1));
        m_resp_kind = 2'($urandom);
        m_resp_data = DW'($urandom);
        m_snp_valid = ($urandom_range(99) < load / 4);
        m_snp_kind = 2'($urandom);
        m_snp_addr = AW'($urandom);
        c_sresp_valid = '0;
        c_sresp_data = (DW*N)'({$urandom, $urandom});
        if ($urandom_range(99) < load / 3) begin
            int p, o;
            p = $urandom_range(N - 1);
            o = $urandom_range(N - 1);
            if (o == p) o = N;
            c_sresp_valid[p] = 1'b1;
            c_sresp_origin = '0;
            c_sresp_origin[p*IDW +: IDW] = IDW'(o);
        end
    endtask

    initial begin
        #15;
        check("R11", "busy in reset", busy, 1'b0);
        check("R11", "m_req_valid in reset", m_req_valid, 1'b0);
        @(posedge clk); #2 rst_n = 1'b1;
        // R11: pointer at port 0 -> all three request, port 0 wins
        c_req_valid = '1;
        #8 compare_cycle();
        check("R11", "first grant", c_req_ready, 3'b001);
        for (int phase = 0; phase < 4; phase++) begin
            busy_len = CW'(phase == 0 ? 0 : (phase == 1 ? 1 : (phase == 2 ? 3 : 6)));
            for (int c = 0; c < 800; c++) begin
                @(posedge clk);
                m_cnt = ev ? int'(busy_len) : (m_cnt > 0 ? m_cnt - 1 : 0);
                if (grant >= 0) m_ptr = (grant + 1) % N;
                #2 drive_random(phase == 3 ? 30 : 70);
                #8 compare_cycle();
            end
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule